// File: doc/BRIEF.md
# Read Data Width Downconverter with Start Alignment

This block feeds a 32-bit outgoing read-data bus from a local source that always supplies 64-bit words. It fetches one local word at a time, stores it, and presents it as two 32-bit halves on successive outgoing data phases. The halves go out low first, then high. The one exception is the first word of a transaction that starts on an odd 32-bit address. In that case the low half of that first word is dropped and the high half goes out first.

A transaction opens with a start pulse that carries the three low start-address bits, and it closes with an end pulse. The end pulse discards any half that has not yet been sent. For each fetched word the local side receives two strobes, one per half, that state which halves were consumed. The block also reports that the transaction is 32 bits wide: its width status output and its 64-bit acknowledge output both stay low.

The controller has four states:
- IDLE: no transaction.
- FETCH: waiting for a local word.
- SEND_LO: offering the low half.
- SEND_HI: offering the high half.

The transitions are:
- IDLE to FETCH, on a start pulse.
- FETCH to SEND_LO, when a word is taken at an aligned start or after the first word.
- FETCH to SEND_HI, when the first word is taken at a misaligned start.
- SEND_LO to SEND_HI, when the low half is accepted.
- SEND_HI to FETCH, when the high half is accepted.
- Any active state to IDLE, on an end pulse. The end pulse has priority over every other transition.

Top module: `rd_width_dnconv`

## Requirements
- R1: After reset, txn_active, out_valid, loc_ready, loc_lo_ack and loc_hi_ack are all 0.
- R2: With start_addr 3'b000, the first word is taken with loc_lo_ack=1 and loc_hi_ack=1. out_data then carries bits [31:0], followed by bits [63:32].
- R3: With start_addr 3'b100, the first word is taken with loc_lo_ack=0 and loc_hi_ack=1. The first out_data carries bits [63:32] of that word, and its bits [31:0] are never sent.
- R4: Every word after the first is taken with both acknowledges at 1 and is sent low half first, then high half.
- R5: loc_ready is 0 while out_valid is 1. loc_ready goes to 1 in the cycle after the high half is accepted (out_valid=1 and out_ready=1 at a clock edge).
- R6: While out_valid=1 and out_ready=0, out_valid stays 1 and out_data stays unchanged.
- R7: A txn_end pulse returns the block to IDLE at the next edge, with out_valid=0, loc_ready=0 and txn_active=0. Any pending half is dropped.
- R8: Start address values other than 3'b000 and 3'b100 (for example 3'b010 and 3'b111) behave as 3'b000.
- R9: txn_active is 1 from the edge that samples txn_start until txn_end. Throughout, wide_status=0 and wide_ack=0.
- R10: A txn_start pulse while txn_active=1 has no effect. The alignment captured at the opening start is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_start | input | 1 | Opens a transaction (sampled in IDLE only) |
| start_addr | input | 3 | Low start-address bits captured with txn_start |
| txn_end | input | 1 | Closes the transaction and flushes pending data |
| loc_data | input | 64 | Local read word |
| loc_valid | input | 1 | Local word is available |
| loc_ready | output | 1 | Block is fetching a local word |
| loc_lo_ack | output | 1 | Low half of the taken word is consumed |
| loc_hi_ack | output | 1 | High half of the taken word is consumed |
| out_data | output | 32 | Outgoing half-word |
| out_valid | output | 1 | out_data holds a half to send |
| out_ready | input | 1 | Outgoing side accepts the half |
| txn_active | output | 1 | A transaction is open |
| wide_status | output | 1 | 64-bit transaction status, held low |
| wide_ack | output | 1 | 64-bit acknowledge, never asserted |

## Verification
- **Stuck alignment flag.** A stuck or stale alignment flag shows on the first handshake after a start. The flag decides loc_lo_ack, which is combinational on the take, and the first out_data one cycle later.
- **Wrong state.** A state that skips or repeats a half shows as a wrong out_data, or as loc_ready rising too early, within one outgoing handshake.
- **Failed flush.** A flush that fails leaves out_valid or txn_active high one cycle after txn_end.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FETCH   = 2'd1,
        ST_SEND_LO = 2'd2,
        ST_SEND_HI = 2'd3
    } rdc_state_e;

    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] ODD_DWORD = 3'b100;
endpackage

// File: rtl/rdc_word_buf.sv
module rdc_word_buf #(
    parameter int LOC_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [LOC_W-1:0]   din,
    input  logic               sel_hi,
    output logic [LOC_W/2-1:0] dout
);
    localparam int HALF_W = LOC_W / 2;

    logic [LOC_W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= din;
        end
    end

    assign dout = sel_hi ? word_q[LOC_W-1:HALF_W] : word_q[HALF_W-1:0];

    // The stored word changes only when a new local word is taken.
    p_word_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(word_q));
endmodule

// File: rtl/rdc_ctrl.sv
module rdc_ctrl
    import rdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              txn_end,
    input  logic              loc_valid,
    input  logic              out_ready,
    output rdc_state_e        state,
    output logic              first_skip
);
    rdc_state_e state_d;
    logic       skip_d;

    always_comb begin
        state_d = state;
        skip_d  = first_skip;
        unique case (state)
            ST_IDLE: begin
                if (txn_start) begin
                    state_d = ST_FETCH;
                    skip_d  = (start_addr == ODD_DWORD);
                end
            end
            ST_FETCH: begin
                if (loc_valid) begin
                    state_d = first_skip ? ST_SEND_HI : ST_SEND_LO;
                    skip_d  = 1'b0;
                end
            end
            ST_SEND_LO: begin
                if (out_ready) state_d = ST_SEND_HI;
            end
            ST_SEND_HI: begin
                if (out_ready) state_d = ST_FETCH;
            end
            default: state_d = ST_IDLE;
        endcase
        if (txn_end && state != ST_IDLE) begin
            state_d = ST_IDLE;
            skip_d  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            first_skip <= 1'b0;
        end else begin
            state      <= state_d;
            first_skip <= skip_d;
        end
    end

    // The skip flag is only live before the first word is taken.
    p_skip_only_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        first_skip |-> (state == ST_FETCH));
endmodule

// File: rtl/rd_width_dnconv.sv
module rd_width_dnconv
    import rdc_pkg::*;
#(
    parameter int LOC_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               txn_start,
    input  logic [2:0]         start_addr,
    input  logic               txn_end,
    input  logic [LOC_W-1:0]   loc_data,
    input  logic               loc_valid,
    output logic               loc_ready,
    output logic               loc_lo_ack,
    output logic               loc_hi_ack,
    output logic [LOC_W/2-1:0] out_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic               txn_active,
    output logic               wide_status,
    output logic               wide_ack
);
    rdc_state_e state;
    logic       first_skip;
    logic       take;

    rdc_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .txn_start  (txn_start),
        .start_addr (start_addr),
        .txn_end    (txn_end),
        .loc_valid  (loc_valid),
        .out_ready  (out_ready),
        .state      (state),
        .first_skip (first_skip)
    );

    always_comb begin
        loc_ready   = 1'b0;
        out_valid   = 1'b0;
        txn_active  = 1'b1;
        wide_status = 1'b0;
        wide_ack    = 1'b0;
        unique case (state)
            ST_IDLE:    txn_active = 1'b0;
            ST_FETCH:   loc_ready  = !txn_end;
            ST_SEND_LO: out_valid  = 1'b1;
            ST_SEND_HI: out_valid  = 1'b1;
            default:    txn_active = 1'b0;
        endcase
        take       = loc_ready && loc_valid;
        loc_hi_ack = take;
        loc_lo_ack = take && !first_skip;
    end

    rdc_word_buf #(.LOC_W(LOC_W)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (take),
        .din    (loc_data),
        .sel_hi (state == ST_SEND_HI),
        .dout   (out_data)
    );

    p_lo_needs_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        loc_lo_ack |-> loc_hi_ack);

    p_no_fetch_while_send_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !loc_ready);

    p_fetch_after_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND_HI && out_ready && !txn_end) |=> (state == ST_FETCH));

    p_hold_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !txn_end) |=> (out_valid && $stable(out_data)));

    p_end_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        txn_end |=> (!txn_active && !out_valid));
endmodule

// File: tb/rd_width_dnconv_tb.sv
module rd_width_dnconv_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        txn_start = 1'b0;
    logic [2:0]  start_addr = 3'b000;
    logic        txn_end = 1'b0;
    logic [63:0] loc_data = '0;
    logic        loc_valid = 1'b0;
    logic        loc_ready, loc_lo_ack, loc_hi_ack;
    logic [31:0] out_data;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic        txn_active, wide_status, wide_ack;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    rd_width_dnconv u_dut (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .start_addr(start_addr),
        .txn_end(txn_end), .loc_data(loc_data), .loc_valid(loc_valid),
        .loc_ready(loc_ready), .loc_lo_ack(loc_lo_ack), .loc_hi_ack(loc_hi_ack),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .txn_active(txn_active), .wide_status(wide_status), .wide_ack(wide_ack)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic open_txn(input logic [2:0] a);
        @(negedge clk);
        txn_start = 1'b1; start_addr = a;
        @(negedge clk);
        txn_start = 1'b0; start_addr = 3'b000;
        chk("R9 active", txn_active, 1);
        chk("R9 wide", {wide_status, wide_ack}, 0);
    endtask

    task automatic close_txn();
        @(negedge clk);
        txn_end = 1'b1;
        @(negedge clk);
        txn_end = 1'b0;
        chk("R7 inactive", txn_active, 0);
        chk("R7 no valid", out_valid, 0);
        chk("R7 no ready", loc_ready, 0);
    endtask

    // at a negedge with the block in FETCH
    task automatic give(input string tag, input logic [63:0] d, input logic lo, input logic hi);
        loc_valid = 1'b1; loc_data = d;
        #1;
        chk({tag, " ready"}, loc_ready, 1);
        chk({tag, " lo_ack"}, loc_lo_ack, lo);
        chk({tag, " hi_ack"}, loc_hi_ack, hi);
        @(negedge clk);
        loc_valid = 1'b0; loc_data = '0;
    endtask

    task automatic sink(input string tag, input logic [31:0] exp);
        chk({tag, " valid"}, out_valid, 1);
        chk({tag, " data"}, out_data, exp);
        chk("R5 no fetch", loc_ready, 0);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 active", txn_active, 0);
        chk("R1 valid", out_valid, 0);
        chk("R1 ready", loc_ready, 0);
        chk("R1 acks", {loc_lo_ack, loc_hi_ack}, 0);
    endtask

    task automatic t_aligned();
        open_txn(3'b000);
        give("R2 w0", 64'h1111_2222_3333_4444, 1, 1);
        sink("R2 lo", 32'h3333_4444);
        sink("R2 hi", 32'h1111_2222);
        chk("R5 ready after hi", loc_ready, 1);
        give("R4 w1", 64'hAAAA_BBBB_CCCC_DDDD, 1, 1);
        sink("R4 lo", 32'hCCCC_DDDD);
        sink("R4 hi", 32'hAAAA_BBBB);
        chk("R9 wide mid", {wide_status, wide_ack}, 0);
        close_txn();
    endtask

    task automatic t_misaligned();
        open_txn(3'b100);
        give("R3 w0", 64'h0BAD_F00D_DEAD_BEEF, 0, 1);
        sink("R3 first hi", 32'h0BAD_F00D);
        chk("R3 ready after hi", loc_ready, 1);
        give("R4 w1", 64'h5555_6666_7777_8888, 1, 1);
        sink("R4 lo", 32'h7777_8888);
        sink("R4 hi", 32'h5555_6666);
        close_txn();
    endtask

    task automatic t_hold();
        open_txn(3'b000);
        give("R6 w0", 64'h0102_0304_0506_0708, 1, 1);
        for (int i = 0; i < 3; i++) begin
            chk("R6 hold valid", out_valid, 1);
            chk("R6 hold data", out_data, 32'h0506_0708);
            @(negedge clk);
        end
        sink("R6 lo", 32'h0506_0708);
        for (int i = 0; i < 2; i++) begin
            chk("R6 hold hi", out_data, 32'h0102_0304);
            @(negedge clk);
        end
        sink("R6 hi", 32'h0102_0304);
        close_txn();
    endtask

    task automatic t_flush();
        open_txn(3'b000);
        give("R7 w0", 64'hFEED_FACE_CAFE_BABE, 1, 1);
        chk("R7 pending", out_valid, 1);
        close_txn();
        open_txn(3'b000);
        give("R7 fresh", 64'h9999_0000_1234_5678, 1, 1);
        sink("R7 fresh lo", 32'h1234_5678);
        close_txn();
    endtask

    task automatic t_other_addr();
        open_txn(3'b010);
        give("R8 010", 64'h2222_0000_3333_0000, 1, 1);
        sink("R8 010 lo", 32'h3333_0000);
        close_txn();
        open_txn(3'b111);
        give("R8 111", 64'h4444_0000_5555_0000, 1, 1);
        sink("R8 111 lo", 32'h5555_0000);
        close_txn();
    endtask

    task automatic t_restart_ignored();
        open_txn(3'b100);
        txn_start = 1'b1; start_addr = 3'b000;
        @(negedge clk);
        txn_start = 1'b0;
        give("R10 w0", 64'h7777_AAAA_8888_BBBB, 0, 1);
        sink("R10 first hi", 32'h7777_AAAA);
        txn_start = 1'b1; start_addr = 3'b100;
        @(negedge clk);
        txn_start = 1'b0; start_addr = 3'b000;
        chk("R10 still fetch", loc_ready, 1);
        give("R10 w1", 64'h1357_2468_ACE0_BDF1, 1, 1);
        sink("R10 lo", 32'hACE0_BDF1);
        close_txn();
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #35;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_aligned();
        t_misaligned();
        t_hold();
        t_flush();
        t_other_addr();
        t_restart_ignored();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule